// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command front end and program controller of a NOR-style flash memory. A host drives it through a synchronous port. Each cycle with `wr_en` high delivers one address and one data word. The low byte of the data word is read as a command code whenever the controller is waiting for a command. Reads are combinational. The value returned depends on the current read mode: cell contents, the status byte, or the extended status byte with the buffer-available flag in bit 7.

Two program flows are decoded. The first is a single-word program that takes two writes. The second is a buffered program: a setup write, then a word-count write, then one write per data word, then a confirm write. A small internal cell array stands in for the flash. It has per-block lock inputs, a program-voltage-valid input and a test-only stuck-at-1 mask. Programming ANDs new data into the old contents. Each word then keeps the controller busy for a fixed number of cycles. Errors are latched as pairs of status bits, and while a sequence error or program error is latched, new buffered writes are refused.

Top module: `flash_cui`

## Requirements
- R1: After reset `ready` is 1, every cell reads FFFFh in array mode, and after clear-status (50h) the status read returns 0080h (bit 7 ready, no error bits).
- R2: With no error latched, a buffer-setup write (E8h) moves reads to extended status, which returns 0080h (bit 7 = buffer available).
- R3: A buffer-setup write while status bit 5 or bit 4 is set is refused: extended status reads 0000h, and the following count, data and D0h writes are treated as commands and leave the array unchanged.
- R4: A buffered program takes a count write holding N-1 in its low 5 bits, then N loads inside the window [start, start+N), then D0h. Each loaded cell becomes old AND data. Programming never sets a bit.
- R5: After a confirm, `ready` (status bit 7) stays 0 for exactly N x PROG_CYCLES cycles, then returns to 1.
- R6: Any write other than D0h after the last load aborts the program and sets status bits 5 and 4 (status 00B0h), and the array is unchanged.
- R7: A first load whose in-block offset plus N exceeds the erase-block size (64 words), or which lies outside the setup block, aborts with status bits 5 and 4 set.
- R8: A later load whose address is outside [start, start+N) aborts with status bits 5 and 4 set.
- R9: If `vpp_ok` is 0 at launch, no cell is written and status bits 4 and 3 are set (status 0098h).
- R10: If the lock input of the target block is 1 at launch, no cell is written and status bits 4 and 1 are set (status 0092h).
- R11: A cell bit that is marked in `stuck_mask` and has old value 1 stays 1. If any bit meant to be 0 reads 1 after a word is written, that word is stored as written, programming stops there, and only status bit 4 is set (status 0090h).
- R12: Setup 40h or the alternate 10h, followed by one address/data write, programs one word. Reads return status right after the setup, and the controller is busy for PROG_CYCLES cycles.
- R13: Clear-status (50h) clears status bits 5, 4, 3 and 1, after which buffer setup is accepted again. FFh returns reads to array mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe, one write per cycle |
| addr | input | ADDR_W | Word address for writes and reads |
| wdata | input | DATA_W | Write data; low byte is the command code |
| rdata | output | DATA_W | Read data in the current read mode |
| ready | output | 1 | 1 when idle, 0 while programming (status bit 7) |
| vpp_ok | input | 1 | Program voltage valid |
| lock_bits | input | 2**ADDR_W/BLK_WORDS | Per-block lock, 1 = locked |
| stuck_mask | input | DATA_W | Test-only stuck-at-1 bit mask |

## Verification
The bench targets the abort paths. A design that lets a bad confirm, a boundary overrun or an out-of-window load reach the array shows changed cells and a status without bits 5 and 4. It also checks that refusal while an error is latched really refuses: a design that accepts the setup anyway reads back an available flag, or swallows the following writes as a sequence. A forced stuck bit checks that programming stops at the failing word and does not run on through the rest of the buffer. The busy length is counted per word, so an off-by-one in the word sequencer or the tick counter shows up as a wrong cycle count.

// File: rtl/flash_cui_pkg.sv
package flash_cui_pkg;

    localparam logic [7:0] CMD_BUF_SETUP = 8'hE8;
    localparam logic [7:0] CMD_CONFIRM   = 8'hD0;
    localparam logic [7:0] CMD_CLR_STAT  = 8'h50;
    localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_WORD_PGM  = 8'h40;
    localparam logic [7:0] CMD_WORD_ALT  = 8'h10;

    localparam int SR_READY = 7;
    localparam int SR_SEQ   = 5;
    localparam int SR_PGM   = 4;
    localparam int SR_VOLT  = 3;
    localparam int SR_LOCK  = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COUNT,
        ST_LOAD,
        ST_CONFIRM,
        ST_WORD,
        ST_PROG
    } cui_state_e;

    typedef enum logic [1:0] {
        MD_ARRAY,
        MD_STATUS,
        MD_XSTATUS
    } cui_mode_e;

endpackage

// File: rtl/flash_cui_array.sv
module flash_cui_array #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells_q[i] <= '1;
        end else if (we) begin
            cells_q[waddr] <= wdata;
        end
    end

    assign rdata_a = cells_q[raddr_a];
    assign rdata_b = cells_q[raddr_b];

endmodule

// File: rtl/flash_cui_wbuf.sv
module flash_cui_wbuf #(
    parameter int DATA_W    = 16,
    parameter int BUF_WORDS = 32,
    localparam int BUF_AW   = $clog2(BUF_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [BUF_AW-1:0] widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BUF_AW-1:0] ridx,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] slot_q [BUF_WORDS];

    // Unloaded slots hold all ones so they leave cells untouched.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BUF_WORDS; i++) slot_q[i] <= '1;
        end else if (clr) begin
            for (int i = 0; i < BUF_WORDS; i++) slot_q[i] <= '1;
        end else if (we) begin
            slot_q[widx] <= wdata;
        end
    end

    assign rdata = slot_q[ridx];

endmodule

// File: rtl/flash_cui.sv
module flash_cui #(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 8,
    parameter int BLK_WORDS   = 64,
    parameter int BUF_WORDS   = 32,
    parameter int PROG_CYCLES = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [DATA_W-1:0]                   wdata,
    output logic [DATA_W-1:0]                   rdata,
    output logic                                ready,
    input  logic                                vpp_ok,
    input  logic [(2**ADDR_W)/BLK_WORDS-1:0]    lock_bits,
    input  logic [DATA_W-1:0]                   stuck_mask
);
    import flash_cui_pkg::*;

    localparam int BLK_AW = $clog2(BLK_WORDS);
    localparam int BLK_IW = ADDR_W - BLK_AW;
    localparam int BUF_AW = $clog2(BUF_WORDS);
    localparam int TICK_W = $clog2(PROG_CYCLES + 1);
    localparam logic [BLK_AW+1:0] BLK_LIM  = (BLK_AW+2)'(BLK_WORDS);
    localparam logic [BUF_AW:0]   ONE_C    = (BUF_AW+1)'(1);
    localparam logic [TICK_W-1:0] LAST_TCK = TICK_W'(PROG_CYCLES - 1);

    typedef struct packed {
        cui_state_e        st;
        cui_mode_e         mode;
        logic [7:0]        sr;
        logic              xsr7;
        logic [BLK_IW-1:0] blk;
        logic [ADDR_W-1:0] start;
        logic [BUF_AW:0]   cnt;
        logic [BUF_AW:0]   remain;
        logic              first;
        logic [BUF_AW-1:0] idx;
        logic [TICK_W-1:0] tick;
    } ctl_t;

    ctl_t q, d;

    logic [7:0]        cmd;
    logic              mem_we;
    logic [ADDR_W-1:0] prog_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] cell_rd;
    logic [DATA_W-1:0] cell_old;
    logic              buf_clr;
    logic              buf_we;
    logic [BUF_AW-1:0] buf_widx;
    logic [DATA_W-1:0] buf_rd;
    logic [BLK_AW+1:0] span;
    logic [ADDR_W-1:0] offs;
    logic              in_win;
    logic [ADDR_W-1:0] launch_addr;
    logic              launch_locked;
    logic              word_fail;

    // Signals brought out for the bound checker.
    logic              in_idle;
    logic              in_confirm;
    logic [7:0]        sr_w;
    logic              xsr7_w;

    assign cmd = wdata[7:0];

    flash_cui_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (mem_we),
        .waddr   (prog_addr),
        .wdata   (mem_wdata),
        .raddr_a (addr),
        .rdata_a (cell_rd),
        .raddr_b (prog_addr),
        .rdata_b (cell_old)
    );

    flash_cui_wbuf #(.DATA_W(DATA_W), .BUF_WORDS(BUF_WORDS)) u_wbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (buf_clr),
        .we    (buf_we),
        .widx  (buf_widx),
        .wdata (wdata),
        .ridx  (q.idx),
        .rdata (buf_rd)
    );

    // Address checks for buffer loads and launch.
    assign span          = {2'b00, addr[BLK_AW-1:0]} + (BLK_AW+2)'(q.cnt);
    assign offs          = addr - q.start;
    assign in_win        = offs < ADDR_W'(q.cnt);
    assign launch_addr   = (q.st == ST_WORD) ? addr : q.start;
    assign launch_locked = lock_bits[launch_addr[ADDR_W-1:BLK_AW]];

    // Program datapath: cells can only lose ones; stuck bits keep old ones.
    assign prog_addr = q.start + ADDR_W'(q.idx);
    assign mem_wdata = (cell_old & buf_rd) | (cell_old & stuck_mask);
    assign word_fail = |(mem_wdata & ~buf_rd);

    always_comb begin
        d        = q;
        mem_we   = 1'b0;
        buf_clr  = 1'b0;
        buf_we   = 1'b0;
        buf_widx = '0;

        unique case (q.st)
            ST_IDLE: begin
                if (wr_en) begin
                    if (cmd == CMD_BUF_SETUP) begin
                        d.mode = MD_XSTATUS;
                        if (q.sr[SR_SEQ] || q.sr[SR_PGM]) begin
                            d.xsr7 = 1'b0;
                        end else begin
                            d.xsr7  = 1'b1;
                            d.blk   = addr[ADDR_W-1:BLK_AW];
                            d.st    = ST_COUNT;
                            buf_clr = 1'b1;
                        end
                    end else if (cmd == CMD_WORD_PGM || cmd == CMD_WORD_ALT) begin
                        d.mode = MD_STATUS;
                        d.st   = ST_WORD;
                    end else if (cmd == CMD_CLR_STAT) begin
                        d.mode         = MD_STATUS;
                        d.sr[SR_SEQ]   = 1'b0;
                        d.sr[SR_PGM]   = 1'b0;
                        d.sr[SR_VOLT]  = 1'b0;
                        d.sr[SR_LOCK]  = 1'b0;
                    end else if (cmd == CMD_RD_ARRAY) begin
                        d.mode = MD_ARRAY;
                    end
                end
            end

            ST_COUNT: begin
                if (wr_en) begin
                    d.cnt    = {1'b0, wdata[BUF_AW-1:0]} + ONE_C;
                    d.remain = {1'b0, wdata[BUF_AW-1:0]} + ONE_C;
                    d.first  = 1'b1;
                    d.mode   = MD_STATUS;
                    d.st     = ST_LOAD;
                end
            end

            ST_LOAD: begin
                if (wr_en) begin
                    if (q.first) begin
                        if (addr[ADDR_W-1:BLK_AW] != q.blk || span > BLK_LIM) begin
                            d.sr[SR_SEQ] = 1'b1;
                            d.sr[SR_PGM] = 1'b1;
                            d.st         = ST_IDLE;
                        end else begin
                            d.start  = addr;
                            d.first  = 1'b0;
                            buf_we   = 1'b1;
                            buf_widx = '0;
                            d.remain = q.remain - ONE_C;
                            if (q.remain == ONE_C) d.st = ST_CONFIRM;
                        end
                    end else if (!in_win) begin
                        d.sr[SR_SEQ] = 1'b1;
                        d.sr[SR_PGM] = 1'b1;
                        d.st         = ST_IDLE;
                    end else begin
                        buf_we   = 1'b1;
                        buf_widx = offs[BUF_AW-1:0];
                        d.remain = q.remain - ONE_C;
                        if (q.remain == ONE_C) d.st = ST_CONFIRM;
                    end
                end
            end

            ST_CONFIRM, ST_WORD: begin
                if (wr_en) begin
                    if (q.st == ST_WORD) begin
                        d.start  = addr;
                        d.cnt    = ONE_C;
                        buf_we   = 1'b1;
                        buf_widx = '0;
                    end
                    if (q.st == ST_CONFIRM && cmd != CMD_CONFIRM) begin
                        d.sr[SR_SEQ] = 1'b1;
                        d.sr[SR_PGM] = 1'b1;
                        d.st         = ST_IDLE;
                    end else if (!vpp_ok) begin
                        d.sr[SR_PGM]  = 1'b1;
                        d.sr[SR_VOLT] = 1'b1;
                        d.st          = ST_IDLE;
                    end else if (launch_locked) begin
                        d.sr[SR_PGM]  = 1'b1;
                        d.sr[SR_LOCK] = 1'b1;
                        d.st          = ST_IDLE;
                    end else begin
                        d.sr[SR_READY] = 1'b0;
                        d.xsr7         = 1'b0;
                        d.idx          = '0;
                        d.tick         = '0;
                        d.mode         = MD_STATUS;
                        d.st           = ST_PROG;
                    end
                end
            end

            ST_PROG: begin
                if (q.tick == LAST_TCK) begin
                    mem_we = 1'b1;
                    d.tick = '0;
                    if (word_fail) begin
                        d.sr[SR_PGM]   = 1'b1;
                        d.sr[SR_READY] = 1'b1;
                        d.st           = ST_IDLE;
                    end else if ({1'b0, q.idx} == q.cnt - ONE_C) begin
                        d.sr[SR_READY] = 1'b1;
                        d.st           = ST_IDLE;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end else begin
                    d.tick = q.tick + 1'b1;
                end
            end

            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.mode   <= MD_ARRAY;
            q.sr     <= 8'h80;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (q.mode)
            MD_STATUS:  rdata = {{(DATA_W-8){1'b0}}, q.sr};
            MD_XSTATUS: rdata = {{(DATA_W-8){1'b0}}, q.xsr7, 7'b0};
            default:    rdata = cell_rd;
        endcase
    end

    assign ready      = q.sr[SR_READY];
    assign in_idle    = (q.st == ST_IDLE);
    assign in_confirm = (q.st == ST_CONFIRM);
    assign sr_w       = q.sr;
    assign xsr7_w     = q.xsr7;

endmodule

// File: rtl/flash_cui_chk.sv
module flash_cui_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [7:0]        cmd,
    input logic              ready,
    input logic              sr5,
    input logic              sr4,
    input logic              sr3,
    input logic              sr1,
    input logic              xsr7,
    input logic              in_idle,
    input logic              in_confirm,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [DATA_W-1:0] cell_old
);

    p_refuse_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_idle && cmd == 8'hE8 && (sr5 || sr4)) |=> !xsr7);

    p_only_clear_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((mem_wdata & ~cell_old) == '0));

    p_write_while_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !ready);

    p_bad_confirm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_confirm && cmd != 8'hD0) |=> (sr5 && sr4));

    p_seq_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr5) |-> sr4);

    p_volt_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr3) |-> sr4);

    p_lock_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr1) |-> sr4);

endmodule

bind flash_cui flash_cui_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .cmd        (cmd),
    .ready      (ready),
    .sr5        (sr_w[5]),
    .sr4        (sr_w[4]),
    .sr3        (sr_w[3]),
    .sr1        (sr_w[1]),
    .xsr7       (xsr7_w),
    .in_idle    (in_idle),
    .in_confirm (in_confirm),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .cell_old   (cell_old)
);

// File: tb/flash_cui_tb.sv
`timescale 1ns/1ps
module flash_cui_tb;
    localparam int PC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ready;
    logic        vpp_ok = 1'b1;
    logic [3:0]  lock_bits = '0;
    logic [15:0] stuck_mask = '0;

    int checks = 0;
    int errors = 0;
    logic [15:0] mdl [256];
    logic [15:0] bufd [32];

    always #4 clk = ~clk;

    flash_cui #(.PROG_CYCLES(PC)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ready(ready), .vpp_ok(vpp_ok), .lock_bits(lock_bits),
        .stuck_mask(stuck_mask)
    );

    function automatic logic [15:0] prog_res(input logic [15:0] old, input logic [15:0] dat,
                                             input logic [15:0] stk);
        return (old & dat) | (old & stk);
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [7:0] a, input logic [15:0] dv);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = dv;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic hr(input logic [7:0] a, output logic [15:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic wait_busy(output int n);
        n = 0;
        while (!ready && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic buf_seq(input logic [7:0] st, input int n, input logic [15:0] conf);
        hw(st, 16'h00E8);
        hw(st, 16'(n - 1));
        for (int i = 0; i < n; i++) hw(st + 8'(i), bufd[i]);
        hw(st, conf);
    endtask

    task automatic cmp_range(input string tag, input logic [7:0] st, input int n);
        logic [15:0] v;
        hw(8'h00, 16'h00FF);
        for (int i = 0; i < n; i++) begin
            hr(st + 8'(i), v);
            chk(tag, v, mdl[st + 8'(i)]);
        end
    endtask

    task automatic clr_stat();
        hw(8'h00, 16'h0050);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] v;
        int n;
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) mdl[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 ready", {15'b0, ready}, 16'h0001);
        hr(8'd5, v); chk("R1 array erased", v, 16'hFFFF);
        clr_stat(); hr(8'd0, v); chk("R1 status", v, 16'h0080);

        // R2, R4, R5 buffered program
        hw(8'd0, 16'h00E8); hr(8'd0, v); chk("R2 buffer available", v, 16'h0080);
        bufd[0] = 16'h1234; bufd[1] = 16'hABCD; bufd[2] = 16'h00FF; bufd[3] = 16'hF00F;
        hw(8'd0, 16'd3);
        for (int i = 0; i < 4; i++) hw(8'(i), bufd[i]);
        hw(8'd0, 16'h00D0);
        wait_busy(n); chk("R5 busy cycles 4 words", 16'(n), 16'(4 * PC));
        hr(8'd0, v); chk("R5 status after", v, 16'h0080);
        for (int i = 0; i < 4; i++) mdl[i] = prog_res(mdl[i], bufd[i], 16'h0);
        cmp_range("R4 programmed", 8'd0, 5);

        // R4 second program only clears bits
        for (int i = 0; i < 4; i++) bufd[i] = 16'h5A5A;
        buf_seq(8'd0, 4, 16'h00D0); wait_busy(n);
        for (int i = 0; i < 4; i++) mdl[i] = prog_res(mdl[i], bufd[i], 16'h0);
        cmp_range("R4 AND with old", 8'd0, 4);

        // R6 bad confirm
        bufd[0] = 16'h0000; bufd[1] = 16'h0000;
        buf_seq(8'd8, 2, 16'h0077);
        hr(8'd0, v); chk("R6 status", v, 16'h00B0);
        cmp_range("R6 array unchanged", 8'd8, 2);

        // R3 refusal while error latched
        hw(8'd20, 16'h00E8); hr(8'd20, v); chk("R3 xsr refused", v, 16'h0000);
        hw(8'd20, 16'h0001); hw(8'd20, 16'h1234); hw(8'd20, 16'h00D0);
        hr(8'd20, v); chk("R3 no sequence status", v, 16'h0000);
        cmp_range("R3 array unchanged", 8'd20, 1);

        // R13 clear then setup accepted
        clr_stat(); hr(8'd0, v); chk("R13 cleared", v, 16'h0080);
        hw(8'd20, 16'h00E8); hr(8'd20, v); chk("R13 setup accepted", v, 16'h0080);
        hw(8'd20, 16'h0000); hw(8'd20, 16'h0F0F); hw(8'd20, 16'h00D0); wait_busy(n);
        mdl[20] = 16'h0F0F;
        cmp_range("R13 program after clear", 8'd20, 1);

        // R7 block overrun
        hw(8'd64, 16'h00E8); hw(8'd64, 16'd7); hw(8'd124, 16'h0000);
        hr(8'd0, v); chk("R7 overrun status", v, 16'h00B0);
        cmp_range("R7 array unchanged", 8'd124, 4);
        clr_stat();
        hw(8'd64, 16'h00E8); hw(8'd64, 16'd0); hw(8'd10, 16'h0000);
        hr(8'd0, v); chk("R7 wrong block status", v, 16'h00B0);
        clr_stat();

        // R8 load outside window
        hw(8'd130, 16'h00E8); hw(8'd130, 16'd3); hw(8'd130, 16'h0000); hw(8'd140, 16'h0000);
        hr(8'd0, v); chk("R8 window status", v, 16'h00B0);
        cmp_range("R8 array unchanged", 8'd130, 1);
        clr_stat();

        // R9 low voltage
        vpp_ok = 1'b0; bufd[0] = 16'h0; bufd[1] = 16'h0;
        buf_seq(8'd200, 2, 16'h00D0);
        hr(8'd0, v); chk("R9 status", v, 16'h0098);
        cmp_range("R9 array unchanged", 8'd200, 2);
        vpp_ok = 1'b1; clr_stat();

        // R10 locked block, buffered and single word
        lock_bits = 4'b0100;
        buf_seq(8'd128, 2, 16'h00D0);
        hr(8'd0, v); chk("R10 status", v, 16'h0092);
        cmp_range("R10 array unchanged", 8'd128, 2);
        clr_stat();
        hw(8'd150, 16'h0040); hw(8'd150, 16'h0000);
        hr(8'd0, v); chk("R10 word status", v, 16'h0092);
        cmp_range("R10 word unchanged", 8'd150, 1);
        lock_bits = '0; clr_stat();

        // R11 stuck bit failure stops at failing word
        stuck_mask = 16'h0001;
        bufd[0] = 16'hF0F1; bufd[1] = 16'h0F0E; bufd[2] = 16'h0000;
        buf_seq(8'd192, 3, 16'h00D0);
        wait_busy(n); chk("R11 busy stops at word 2", 16'(n), 16'(2 * PC));
        hr(8'd0, v); chk("R11 status", v, 16'h0090);
        mdl[192] = prog_res(mdl[192], bufd[0], stuck_mask);
        mdl[193] = prog_res(mdl[193], bufd[1], stuck_mask);
        cmp_range("R11 array", 8'd192, 3);
        stuck_mask = '0; clr_stat();

        // R12 single word, both setup codes
        hw(8'd50, 16'h0040); hr(8'd0, v); chk("R12 status mode", v, 16'h0080);
        hw(8'd50, 16'h3C3C); wait_busy(n); chk("R12 busy", 16'(n), 16'(PC));
        mdl[50] = prog_res(mdl[50], 16'h3C3C, 16'h0);
        hw(8'd51, 16'h0010); hw(8'd51, 16'h7E81); wait_busy(n);
        chk("R12 alt busy", 16'(n), 16'(PC));
        mdl[51] = prog_res(mdl[51], 16'h7E81, 16'h0);
        cmp_range("R12 words", 8'd50, 3);

        // R4 R5 random buffered programs
        for (int it = 0; it < 24; it++) begin
            int cnt = 1 + int'($urandom % 32);
            int blk = int'($urandom % 4);
            int off = int'($urandom % (64 - cnt + 1));
            logic [7:0] st = 8'(blk * 64 + off);
            for (int i = 0; i < cnt; i++) bufd[i] = 16'($urandom);
            buf_seq(st, cnt, 16'h00D0);
            wait_busy(n); chk("R5 random busy", 16'(n), 16'(cnt * PC));
            hr(8'd0, v); chk("R4 random status", v, 16'h0080);
            for (int i = 0; i < cnt; i++) mdl[st + 8'(i)] = prog_res(mdl[st + 8'(i)], bufd[i], 16'h0);
            cmp_range("R4 random array", st, cnt);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule